// File: doc/BRIEF.md
# Reciprocal-Estimate and Refinement Divider

This unit divides without a divide datapath. A quotient is built from three operations that are issued one by one: a coarse reciprocal estimate of the divisor, a correction step that turns the estimate into an accurate reciprocal, and a rounded multiply of the dividend by that reciprocal. Each operation is accepted on its own. A scheduler can therefore place unrelated work between the three steps, or overlap the steps of several divisions.

All operands and results are 24-bit unsigned fixed-point numbers with one integer bit and 23 fraction bits. Divisors and dividends are normalized mantissas in [1,2), so bit 23 is set. Reciprocals fall in (0.5,1] and use the same format. The coarse estimate comes from a computed table of 512 entries. The estimate is exact in only about its top ten bits. The correction step applies a third-order Newton-type update, x·(1 + e + e²) with e = 1 − b·x. This lifts the estimate to full precision in one pass. Every operation has the same three-cycle latency, and one operation may enter on every cycle.

Top module: `recip_div_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, the pipeline is cleared. After reset `out_valid` is 0 and `out_result` is 0, and an operation that was in flight when reset arrived never produces `out_valid`.
- R2: Opcode 2'b00 (estimate) returns S·2^13, where i = `in_b`[22:14] (the nine fraction bits below the leading one) and S = the nearest integer to 2^20/(1025+2i). `in_a` is ignored. The low 13 result bits are zero, bit 23 is 0 and bit 22 is 1.
- R3: For any accepted operation (opcode 2'b00, 2'b01 or 2'b10 with `in_valid` high at edge N), `out_valid` is high for exactly one cycle after edge N+2, and it is low in the two samples before that.
- R4: Opcode 2'b01 (refine), given `in_a` = the estimate of `in_b` and `in_b` = the divisor, returns a value within 2 LSB of 2^46/`in_b`.
- R5: Opcode 2'b10 (multiply) returns floor((`in_a`·`in_b` + 2^22)/2^23). If that value exceeds 2^24−1, the result is 2^24−1.
- R6: The sequence estimate(b), refine(estimate, b), multiply(a, refined) gives a quotient within 2 LSB of 2^23·a/b.
- R7: Opcode 2'b11 is a no-op. It never raises `out_valid` and leaves `out_result` unchanged.
- R8: While `out_valid` is low, `out_result` keeps its last value.
- R9: Operations of different kinds issued on consecutive cycles each produce their own correct result, in issue order, three cycles after their issue.

Ports table:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 2 | 00 estimate, 01 refine, 10 multiply, 11 no-op |
| in_a | input | 24 | Estimate to refine, or dividend for multiply; unused by estimate |
| in_b | input | 24 | Divisor for estimate and refine, reciprocal for multiply |
| out_valid | output | 1 | Result present this cycle |
| out_result | output | 24 | Result of the operation issued three cycles earlier |

## Verification
In the same cycle, the refine tail can finish the correction of one operation in the last stage while the estimate table or the rounding multiplier works on the next operation in the middle stage. The bench provokes this by issuing an estimate, a multiply, a no-op, a refine, another estimate and a saturating multiply on back-to-back cycles. It then judges each result at its own output cycle against values it computes itself: exact values for the estimate and the multiply, and a 2 LSB bound for the refine. The no-op slot in that stream must show `out_valid` low, with `out_result` still holding the value left by the previous multiply.

// File: rtl/recip_pkg.sv
// Package: opcode encoding shared by the reciprocal divider and its bench.
// Assumes a two-bit opcode field; the encoding is fixed by the interface.
package recip_pkg;
    typedef enum logic [1:0] {
        OP_EST    = 2'b00,
        OP_REFINE = 2'b01,
        OP_MUL    = 2'b10,
        OP_NONE   = 2'b11
    } op_e;
endpackage

// File: rtl/recip_seed_rom.sv
// Seed table: maps the top IDX_W fraction bits of a normalized mantissa to
// a (IDX_W+1)-bit reciprocal seed S, value S / 2^(IDX_W+1), rounded to nearest
// at the centre of each interval. Entries are computed at elaboration.
// Assumes bit W-1 of the operand is set (mantissa in [1,2)).
module recip_seed_rom #(
    parameter int W     = 24,
    parameter int IDX_W = 9
) (
    input  logic [W-1:0]   mant,
    output logic [IDX_W:0] seed
);
    localparam int ROWS = 1 << IDX_W;
    localparam int FRAC = W - 1;

    // Nearest integer to 2^(2(IDX_W+1)) / (2^(IDX_W+1) + 2i + 1).
    function automatic int seed_of(input int i);
        longint den;
        longint num;
        den = (longint'(1) << (IDX_W + 1)) + 2 * i + 1;
        num = longint'(1) << (2 * (IDX_W + 1));
        return int'((2 * num + den) / (2 * den));
    endfunction

    logic [IDX_W-1:0] rom [ROWS];

    for (genvar g = 0; g < ROWS; g++) begin : g_row
        localparam int SV = seed_of(g);
        assign rom[g] = SV[IDX_W-1:0];
    end

    // Lookup: leading one is implied, table stores the bits below it.
    always_comb seed = {1'b1, rom[mant[FRAC-1 -: IDX_W]]};
endmodule

// File: rtl/recip_mul_round.sv
// Rounded fixed-point multiply of two 1.(W-1) numbers into a 1.(W-1) result,
// round half up, saturating to all ones when the product reaches 2.0.
module recip_mul_round #(
    parameter int W = 24
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] q
);
    localparam int FRAC = W - 1;
    localparam logic [2*W-1:0] HALF = (2*W)'(1) << (FRAC - 1);

    logic [2*W-1:0] prod;
    logic [2*W-1:0] rnd;

    // Full product, round at the result LSB, clamp on overflow.
    always_comb begin
        prod = {{W{1'b0}}, a} * {{W{1'b0}}, b};
        rnd  = (prod + HALF) >> FRAC;
        q    = (|rnd[2*W-1:W]) ? {W{1'b1}} : rnd[W-1:0];
    end
endmodule

// File: rtl/recip_err_calc.sv
// First half of the refine step: residual e = 1 - b*x, kept signed with EF
// fraction bits (truncated toward minus infinity).
// Assumes x and b are 1.(W-1) numbers; XW is wide enough for 2W+2 bits.
module recip_err_calc #(
    parameter int W  = 24,
    parameter int EF = 30,
    parameter int XW = 64
) (
    input  logic [W-1:0]          x,
    input  logic [W-1:0]          b,
    output logic signed [XW-1:0]  err
);
    localparam int FRAC = W - 1;
    localparam int SH   = 2 * FRAC - EF;
    localparam logic signed [XW-1:0] ONE = XW'(1) << (2 * FRAC);

    logic [2*W-1:0]         prod;
    logic signed [XW-1:0]   prod_s;
    logic signed [XW-1:0]   resid;

    // Residual of the current approximation, rescaled to EF fraction bits.
    always_comb begin
        prod   = {{W{1'b0}}, x} * {{W{1'b0}}, b};
        prod_s = $signed({{(XW-2*W){1'b0}}, prod});
        resid  = ONE - prod_s;
        err    = resid >>> SH;
    end
endmodule

// File: rtl/recip_refine_tail.sv
// Second half of the refine step: x' = x * (1 + e + e^2), rounded to the
// result LSB and clamped to the unsigned W-bit range.
// Assumes err carries EF fraction bits as produced by recip_err_calc.
module recip_refine_tail #(
    parameter int W  = 24,
    parameter int EF = 30,
    parameter int XW = 64
) (
    input  logic [W-1:0]          x,
    input  logic signed [XW-1:0]  err,
    output logic [W-1:0]          x_new
);
    localparam logic signed [XW-1:0] HALF = XW'(1) << (EF - 1);
    localparam logic signed [XW-1:0] MAXV = XW'((longint'(1) << W) - 1);

    logic signed [XW-1:0] x_s;
    logic signed [XW-1:0] sq;
    logic signed [XW-1:0] corr;
    logic signed [XW-1:0] acc;
    logic signed [XW-1:0] res;

    // Third-order correction term, applied to x with rounding and clamping.
    always_comb begin
        x_s  = $signed({{(XW-W){1'b0}}, x});
        sq   = (err * err) >>> EF;
        corr = err + sq;
        acc  = (x_s <<< EF) + x_s * corr + HALF;
        res  = acc >>> EF;
        if (res < 0)
            x_new = '0;
        else if (res > MAXV)
            x_new = {W{1'b1}};
        else
            x_new = res[W-1:0];
    end
endmodule

// File: rtl/recip_div_unit.sv
// Reciprocal-estimate and refinement divider. Three independent operations
// (estimate, refine, multiply) share a three-stage pipeline: capture, first
// arithmetic stage, second arithmetic stage / result register. One operation
// may enter per cycle; opcode 2'b11 is dropped at capture.
// Assumes normalized operands in [1,2) for estimate and refine.
module recip_div_unit
    import recip_pkg::*;
#(
    parameter int W     = 24,
    parameter int IDX_W = 9,
    parameter int EF    = 30
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [1:0]   in_op,
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    output logic         out_valid,
    output logic [W-1:0] out_result
);
    localparam int FRAC   = W - 1;
    localparam int XW     = 2 * W + 16;
    localparam int EST_SH = FRAC - IDX_W - 1;

    // Stage 1 state
    logic         v1;
    op_e          op1;
    logic [W-1:0] a1;
    logic [W-1:0] b1;
    // Stage 2 state
    logic                 v2;
    op_e                  op2;
    logic [W-1:0]         r2;
    logic [W-1:0]         x2;
    logic signed [XW-1:0] e2;
    // Stage 3 state
    op_e                  s3_op;

    logic [IDX_W:0]       seed_w;
    logic [W-1:0]         est_w;
    logic [W-1:0]         mul_w;
    logic signed [XW-1:0] err_w;
    logic [W-1:0]         ref_w;

    // Capture: register the operation, dropping no-ops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1  <= 1'b0;
            op1 <= OP_NONE;
            a1  <= '0;
            b1  <= '0;
        end else begin
            v1  <= in_valid && (op_e'(in_op) != OP_NONE);
            op1 <= op_e'(in_op);
            a1  <= in_a;
            b1  <= in_b;
        end
    end

    recip_seed_rom #(.W(W), .IDX_W(IDX_W)) u_seed (
        .mant (b1),
        .seed (seed_w)
    );

    recip_mul_round #(.W(W)) u_mul (
        .a (a1),
        .b (b1),
        .q (mul_w)
    );

    recip_err_calc #(.W(W), .EF(EF), .XW(XW)) u_err (
        .x   (a1),
        .b   (b1),
        .err (err_w)
    );

    // Position the seed as a 1.(W-1) value.
    always_comb est_w = W'(seed_w) << EST_SH;

    // Stage 2: hold the finished estimate/product and the refine residual.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v2  <= 1'b0;
            op2 <= OP_NONE;
            r2  <= '0;
            x2  <= '0;
            e2  <= '0;
        end else begin
            v2  <= v1;
            op2 <= op1;
            r2  <= (op1 == OP_MUL) ? mul_w : est_w;
            x2  <= a1;
            e2  <= err_w;
        end
    end

    recip_refine_tail #(.W(W), .EF(EF), .XW(XW)) u_tail (
        .x     (x2),
        .err   (e2),
        .x_new (ref_w)
    );

    // Stage 3: result register, loaded only by a live operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            s3_op      <= OP_NONE;
            out_result <= '0;
        end else begin
            out_valid <= v2;
            s3_op     <= op2;
            if (v2)
                out_result <= (op2 == OP_REFINE) ? ref_w : r2;
        end
    end

    // R1: first cycle out of reset shows an empty pipeline.
    p_rst_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out_valid && out_result == '0));

    // R3: every accepted operation appears three cycles later.
    p_issue_lat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op != 2'b11) |-> ##3 out_valid);

    // R2: an estimate result has the seed shape in (0.5,1).
    p_est_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && s3_op == OP_EST) |->
            (out_result[EST_SH-1:0] == '0 && !out_result[W-1] && out_result[W-2]));

    // R8: the result only moves together with out_valid.
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_result));
endmodule

// File: tb/test_recip_div_unit.sv
// Bench for recip_div_unit: vector table walk of full divisions, then
// directed tests for no-op, hold, saturation, interleaving and reset.
module test_recip_div_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;

    localparam logic [23:0] VA [NV] = '{24'hFFFFFF, 24'h800000, 24'hC90FDB, 24'h8AC7E1,
                                        24'hF00000, 24'h800001, 24'hA00000, 24'hFFFFFF};
    localparam logic [23:0] VB [NV] = '{24'h800000, 24'hFFFFFF, 24'hC00000, 24'hAAAAAA,
                                        24'h9E3779, 24'hB504F3, 24'h800001, 24'hFFC000};

    logic        clk;
    logic        rst_n;
    logic        in_valid;
    logic [1:0]  in_op;
    logic [23:0] in_a;
    logic [23:0] in_b;
    logic        out_valid;
    logic [23:0] out_result;

    int n_checks = 0;
    int n_fail   = 0;

    recip_div_unit i_recip_div_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_op      (in_op),
        .in_a       (in_a),
        .in_b       (in_b),
        .out_valid  (out_valid),
        .out_result (out_result)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint exp_est(input logic [23:0] b);
        int i;
        int s;
        i = int'(b[22:14]);
        s = $rtoi(1048576.0 / (1025.0 + 2.0 * i) + 0.5);
        return longint'(s) << 13;
    endfunction

    function automatic longint exp_mul(input logic [23:0] a, input logic [23:0] b);
        longint r;
        r = (longint'(a) * longint'(b) + (longint'(1) << 22)) >> 23;
        return (r > 16777215) ? 16777215 : r;
    endfunction

    function automatic real exact_recip(input logic [23:0] b);
        return (2.0 ** 46) / real'(b);
    endfunction

    function automatic bit near(input logic [23:0] got, input real want);
        real d;
        d = real'(got) - want;
        return (d <= 2.0) && (d >= -2.0);
    endfunction

    // Issue one operation and return its result, checking the latency (R3).
    task automatic run_op(input logic [1:0] op, input logic [23:0] a, input logic [23:0] b,
                          output logic [23:0] res);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b0, "R3 early sample 1", out_valid, 0);
        @(negedge clk);
        check(out_valid == 1'b0, "R3 early sample 2", out_valid, 0);
        @(negedge clk);
        check(out_valid == 1'b1, "R3 valid at latency 3", out_valid, 1);
        res = out_result;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    logic [1:0]  sop [6];
    logic [23:0] sa  [6];
    logic [23:0] sb  [6];
    logic [23:0] last_res;

    // R9: judge one slot of the back-to-back stream at its output cycle.
    task automatic check_slot(input int j);
        case (sop[j])
            2'b00: begin
                check(out_valid == 1'b1, "R9 est valid", out_valid, 1);
                check(out_result == exp_est(sb[j]), "R9 est value", out_result, exp_est(sb[j]));
            end
            2'b01: begin
                check(out_valid == 1'b1, "R9 refine valid", out_valid, 1);
                check(near(out_result, exact_recip(sb[j])), "R9 refine within 2 LSB",
                      out_result, $rtoi(exact_recip(sb[j]) + 0.5));
            end
            2'b10: begin
                check(out_valid == 1'b1, "R9 mul valid", out_valid, 1);
                check(out_result == exp_mul(sa[j], sb[j]), "R9 mul value",
                      out_result, exp_mul(sa[j], sb[j]));
            end
            default: begin
                check(out_valid == 1'b0, "R7 no-op in stream", out_valid, 0);
                check(out_result == last_res, "R7 no-op keeps result", out_result, last_res);
            end
        endcase
        if (sop[j] != 2'b11) last_res = out_result;
    endtask

    initial begin
        logic [23:0] e;
        logic [23:0] r;
        logic [23:0] q;
        logic [23:0] e0;
        logic [23:0] e1;
        logic [23:0] held;

        rst_n = 1'b0; in_valid = 1'b0; in_op = 2'b11; in_a = '0; in_b = '0;
        repeat (4) @(negedge clk);
        check(out_valid == 1'b0, "R1 reset valid", out_valid, 0);
        check(out_result == 24'h0, "R1 reset result", out_result, 0);
        rst_n = 1'b1;

        // Vector walk: full estimate, refine, multiply sequence per pair.
        for (int k = 0; k < NV; k++) begin
            run_op(2'b00, VA[k], VB[k], e);
            check(e == exp_est(VB[k]), "R2 estimate value", e, exp_est(VB[k]));
            run_op(2'b01, e, VB[k], r);
            check(near(r, exact_recip(VB[k])), "R4 refined reciprocal",
                  r, $rtoi(exact_recip(VB[k]) + 0.5));
            run_op(2'b10, VA[k], r, q);
            check(q == exp_mul(VA[k], r), "R5 rounded product", q, exp_mul(VA[k], r));
            check(near(q, real'(VA[k]) * (2.0 ** 23) / real'(VB[k])), "R6 quotient",
                  q, $rtoi(real'(VA[k]) * (2.0 ** 23) / real'(VB[k]) + 0.5));
        end

        // R2: in_a has no effect on the estimate.
        run_op(2'b00, 24'h000000, 24'hB504F3, e0);
        run_op(2'b00, 24'hFFFFFF, 24'hB504F3, e1);
        check(e0 == e1, "R2 in_a ignored", e1, e0);

        // R5: saturation and an exact product.
        run_op(2'b10, 24'hFFFFFF, 24'hFFFFFF, q);
        check(q == 24'hFFFFFF, "R5 saturation", q, 24'hFFFFFF);
        run_op(2'b10, 24'h800000, 24'h800000, q);
        check(q == 24'h800000, "R5 one times one", q, 24'h800000);

        // R8: idle cycles keep the last result.
        held = q;
        repeat (5) @(negedge clk);
        check(out_valid == 1'b0, "R8 idle valid", out_valid, 0);
        check(out_result == held, "R8 result held", out_result, held);

        // R7: a lone no-op with live-looking operands.
        @(negedge clk);
        in_valid = 1'b1; in_op = 2'b11; in_a = 24'h123456; in_b = 24'hABCDEF;
        @(negedge clk);
        in_valid = 1'b0;
        for (int c = 0; c < 4; c++) begin
            check(out_valid == 1'b0, "R7 no-op valid", out_valid, 0);
            check(out_result == held, "R7 no-op result", out_result, held);
            @(negedge clk);
        end

        // R9: mixed operations on consecutive cycles.
        sop[0] = 2'b00; sa[0] = 24'h5A5A5A; sb[0] = 24'hC00000;
        sop[1] = 2'b10; sa[1] = 24'h800000; sb[1] = 24'hC00000;
        sop[2] = 2'b11; sa[2] = 24'hFFFFFF; sb[2] = 24'hFFFFFF;
        sop[3] = 2'b01; sa[3] = 24'(exp_est(24'hC00000)); sb[3] = 24'hC00000;
        sop[4] = 2'b00; sa[4] = 24'h000000; sb[4] = 24'hFFFFFF;
        sop[5] = 2'b10; sa[5] = 24'hFFFFFF; sb[5] = 24'hFFFFFF;
        last_res = out_result;
        for (int k = 0; k < 9; k++) begin
            @(negedge clk);
            if (k >= 3) check_slot(k - 3);
            if (k < 6) begin
                in_valid = 1'b1; in_op = sop[k]; in_a = sa[k]; in_b = sb[k];
            end else begin
                in_valid = 1'b0; in_op = 2'b11;
            end
        end

        // R1: reset while an operation is in flight flushes it.
        @(negedge clk);
        in_valid = 1'b1; in_op = 2'b00; in_a = '0; in_b = 24'h900000;
        @(negedge clk);
        in_valid = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check(out_valid == 1'b0, "R1 flush valid", out_valid, 0);
        check(out_result == 24'h0, "R1 flush result", out_result, 0);
        repeat (3) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R1 flushed op silent", out_valid, 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule